// File: doc/BRIEF.md
# TAP User Test Data Registers

This block holds two test data registers that a TAP controller selects through its instruction decode. The first is a configuration register with no capture stage. It shifts from the serial input and drives its bits onto a parallel output when the controller strobes update. Chip logic uses those bits as test-mode and configuration controls. The second register both captures and updates. Updating its enable bit arms a RAM self-test. Capturing it reads back the engine's completion flag and result bits.

The self-test engine sits outside this block behind a small handshake: a run signal goes out, and a done flag and result bits come in. The run signal is asserted only while the TAP waits in the idle state with the self-test instruction active and the enable set. The TAP supplies the capture, shift and update strobes, a test-logic-reset level and an idle level. This block returns one serial output bit and a flag that tells the TAP's output multiplexer when that bit is valid.

Top module: `tap_user_dregs`

## Requirements
- R1: With `sel_user` high, each `shift_dr` cycle moves the user stage one place toward bit 0: `tdi` enters at bit USER_W-1 and bit 0 drives `tdo`. An `update_dr` cycle copies the stage onto `user_cfg`.
- R2: A `capture_dr` cycle with `sel_user` high leaves the user stage unchanged, so the next shift returns the bits that were scanned in before it.
- R3: `user_cfg` keeps its value during capture and shift and changes only on an `update_dr` cycle.
- R4: With `sel_bist` high, the self-test stage is RES_W+1 bits wide and shifts the same way as the user stage. An `update_dr` cycle loads stage bit 0 into the self-test enable.
- R5: A `capture_dr` cycle with `sel_bist` high loads `bist_done` into stage bit 0 and `bist_result[k]` into stage bit k+1.
- R6: `bist_run` is 1 exactly when the self-test enable is 1, `sel_bist` is high and `run_idle` is high.
- R7: A cycle with `tlr` high, or a low `rst_n`, clears `user_cfg` and the self-test enable to 0. `tlr` takes priority over `update_dr`.
- R8: With neither select high, both stages hold their contents, `tdo_sel` is 0 and `tdo` is 0.
- R9: `tdo_sel` is 1 while either select is high, and `tdo` then shows bit 0 of the selected stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous test reset, active low |
| tlr | input | 1 | TAP is in test-logic-reset |
| run_idle | input | 1 | TAP is in run-test/idle |
| capture_dr | input | 1 | Capture data-register strobe |
| shift_dr | input | 1 | Shift data-register strobe |
| update_dr | input | 1 | Update data-register strobe |
| sel_user | input | 1 | Instruction selects the user register |
| sel_bist | input | 1 | Instruction selects the self-test register |
| tdi | input | 1 | Serial data in |
| bist_done | input | 1 | Self-test engine finished |
| bist_result | input | RES_W | Self-test result bits |
| tdo | output | 1 | Serial data out of this block |
| tdo_sel | output | 1 | `tdo` is valid for the TAP output mux |
| user_cfg | output | USER_W | Parallel user configuration bits |
| bist_run | output | 1 | Run request to the self-test engine |

## Verification
The bench builds the block with USER_W = 6 and RES_W = 4. The two chains then differ in length: six bits against five. A scan sized for the wrong register would show up as misplaced bits in the scoreboard. A four-bit result word is enough to place distinct values in every captured position. Together these settings cover the capture-versus-no-capture contrast, the gating of the run signal and the reset clears within short scans.

// File: rtl/tap_udr_pkg.sv
package tap_udr_pkg;

  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
    logic tlr;
    logic idle;
  } tap_ctl_t;

  function automatic logic run_gate(input logic en, input logic sel, input logic idle);
    return en & sel & idle;
  endfunction

endpackage

// File: rtl/udr_user_reg.sv
module udr_user_reg
  import tap_udr_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tap_ctl_t     ctl,
  input  logic         sel,
  input  logic         tdi,
  output logic [W-1:0] stage,
  output logic [W-1:0] cfg
);

  logic do_shift, do_update;
  assign do_shift  = sel & ctl.shift;
  assign do_update = sel & ctl.update & ~ctl.tlr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
    end else if (do_shift) begin
      stage <= {tdi, stage[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (ctl.tlr) begin
      cfg <= '0;
    end else if (do_update) begin
      cfg <= stage;
    end
  end

  assert_capture_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && ctl.capture && !ctl.shift) |=> $stable(stage));

  assert_update_copies_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && ctl.update && !ctl.tlr) |=> (cfg == $past(stage)));

  assert_cfg_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.update && !ctl.tlr) |=> $stable(cfg));

endmodule

// File: rtl/udr_bist_reg.sv
module udr_bist_reg
  import tap_udr_pkg::*;
#(
  parameter int RES_W = 4,
  localparam int SW = RES_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tap_ctl_t         ctl,
  input  logic             sel,
  input  logic             tdi,
  input  logic             done,
  input  logic [RES_W-1:0] result,
  output logic [SW-1:0]    stage,
  output logic             en_q
);

  logic do_capture, do_shift, do_update;
  assign do_capture = sel & ctl.capture;
  assign do_shift   = sel & ctl.shift;
  assign do_update  = sel & ctl.update & ~ctl.tlr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
    end else if (do_capture) begin
      stage <= {result, done};
    end else if (do_shift) begin
      stage <= {tdi, stage[SW-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (ctl.tlr) begin
      en_q <= 1'b0;
    end else if (do_update) begin
      en_q <= stage[0];
    end
  end

  assert_capture_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    do_capture |=> (stage[0] == $past(done) && stage[SW-1:1] == $past(result)));

  assert_enable_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_update |=> (en_q == $past(stage[0])));

endmodule

// File: rtl/tap_user_dregs.sv
module tap_user_dregs
  import tap_udr_pkg::*;
#(
  parameter int USER_W = 6,
  parameter int RES_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tlr,
  input  logic              run_idle,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              sel_user,
  input  logic              sel_bist,
  input  logic              tdi,
  input  logic              bist_done,
  input  logic [RES_W-1:0]  bist_result,
  output logic              tdo,
  output logic              tdo_sel,
  output logic [USER_W-1:0] user_cfg,
  output logic              bist_run
);

  localparam int BW = RES_W + 1;

  tap_ctl_t          ctl;
  logic [USER_W-1:0] user_stage;
  logic [BW-1:0]     bist_stage;
  logic              bist_en;

  assign ctl = '{capture: capture_dr, shift: shift_dr, update: update_dr,
                 tlr: tlr, idle: run_idle};

  udr_user_reg #(.W(USER_W)) u_user (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .sel(sel_user), .tdi(tdi),
    .stage(user_stage), .cfg(user_cfg)
  );

  udr_bist_reg #(.RES_W(RES_W)) u_bist (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .sel(sel_bist), .tdi(tdi),
    .done(bist_done), .result(bist_result), .stage(bist_stage), .en_q(bist_en)
  );

  assign bist_run = run_gate(bist_en, sel_bist, ctl.idle);
  assign tdo_sel  = sel_user | sel_bist;

  always_comb begin
    if (sel_user)      tdo = user_stage[0];
    else if (sel_bist) tdo = bist_stage[0];
    else               tdo = 1'b0;
  end

  assert_run_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bist_run |-> (sel_bist && run_idle));

  assert_tlr_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tlr |=> (user_cfg == '0 && bist_en == 1'b0));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_user && !sel_bist) |=> ($stable(user_stage) && $stable(bist_stage)));

  always_comb begin
    if (rst_n && !tdo_sel) assert_no_tdo_R9: assert (tdo == 1'b0);
  end

endmodule

// File: tb/tap_user_dregs_tb.sv
module tap_user_dregs_tb;

  localparam int UW = 6;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tlr = 1'b0, run_idle = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic sel_user = 1'b0, sel_bist = 1'b0, tdi = 1'b0, bist_done = 1'b0;
  logic [RW-1:0] bist_result = '0;
  logic tdo, tdo_sel, bist_run;
  logic [UW-1:0] user_cfg;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  logic  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  tap_user_dregs #(.USER_W(UW), .RES_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tlr(tlr), .run_idle(run_idle),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .sel_user(sel_user), .sel_bist(sel_bist), .tdi(tdi),
    .bist_done(bist_done), .bist_result(bist_result),
    .tdo(tdo), .tdo_sel(tdo_sel), .user_cfg(user_cfg), .bist_run(bist_run)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected serial bits while a selected shift is in progress
  initial begin
    forever begin
      @(negedge clk); #5;
      if (rst_n && shift_dr && tdo_sel) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected shift", {7'd0, tdo}, 8'd0);
        end else begin
          logic  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(tdo === e, t, {7'd0, tdo}, {7'd0, e});
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_strobes();
    capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0; tlr = 1'b0;
  endtask

  task automatic do_capture();
    step(); idle_strobes(); capture_dr = 1'b1;
  endtask

  task automatic do_update();
    step(); idle_strobes(); update_dr = 1'b1;
  endtask

  // driver: pushes the expected serial output, then shifts n bits in LSB first
  task automatic scan(input int n, input logic [7:0] din, input logic [7:0] dout, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(dout[i]);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < n; i++) begin
      step(); idle_strobes(); shift_dr = 1'b1; tdi = din[i];
    end
  endtask

  task automatic settle();
    step(); idle_strobes(); #5;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    settle();
    check(user_cfg == 0, "R7 reset user_cfg", 8'(user_cfg), 0);
    check(bist_run == 0, "R7 reset bist_run", {7'd0, bist_run}, 0);
    check(tdo_sel == 0 && tdo == 0, "R8 reset no select", {6'd0, tdo_sel, tdo}, 0);

    // user register: capture leaves zeros, shift in A, cfg held until update
    sel_user = 1'b1;
    do_capture();
    scan(UW, 8'b101101, 8'b000000, "R1 user first scan");
    settle();
    check(tdo_sel == 1, "R9 tdo_sel user", {7'd0, tdo_sel}, 1);
    check(user_cfg == 0, "R3 cfg held before update", 8'(user_cfg), 0);
    do_update();
    settle();
    check(user_cfg == 6'b101101, "R1 user update", 8'(user_cfg), 8'b101101);

    // capture must not overwrite: A comes back out
    do_capture();
    scan(UW, 8'b010011, 8'b101101, "R2 user capture holds");
    settle();
    check(user_cfg == 6'b101101, "R3 cfg held during shift", 8'(user_cfg), 8'b101101);
    do_update();
    settle();
    check(user_cfg == 6'b010011, "R1 user second update", 8'(user_cfg), 8'b010011);

    // deselected: shifts and captures ignored
    sel_user = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step(); idle_strobes(); shift_dr = 1'b1; tdi = i[0];
      #5;
      check(tdo_sel == 0 && tdo == 0, "R8 deselected tdo", {6'd0, tdo_sel, tdo}, 0);
    end
    do_capture();
    bist_done = 1'b1; bist_result = 4'hF;
    do_update();
    settle();
    check(user_cfg == 6'b010011, "R8 cfg unchanged deselected", 8'(user_cfg), 8'b010011);
    sel_user = 1'b1;
    scan(UW, 8'b010011, 8'b010011, "R8 user stage held");
    settle();
    sel_user = 1'b0;
    bist_done = 1'b0; bist_result = 4'h0;

    // self-test: capture zeros, set enable
    sel_bist = 1'b1;
    do_capture();
    scan(RW + 1, 8'b00001, 8'b00000, "R5 bist capture idle");
    settle();
    check(bist_run == 0, "R6 no run before update", {7'd0, bist_run}, 0);
    do_update();
    settle();
    check(bist_run == 0, "R6 no run outside idle", {7'd0, bist_run}, 0);
    run_idle = 1'b1; #1;
    check(bist_run == 1, "R4 R6 run in idle", {7'd0, bist_run}, 1);
    sel_bist = 1'b0; sel_user = 1'b1; #1;
    check(bist_run == 0, "R6 run needs bist select", {7'd0, bist_run}, 0);
    sel_user = 1'b0; sel_bist = 1'b1;
    settle();
    run_idle = 1'b0;
    bist_done = 1'b1; bist_result = 4'b1010;
    do_capture();
    scan(RW + 1, 8'b00000, 8'b10101, "R5 bist result readout");
    do_update();
    settle();
    run_idle = 1'b1; #1;
    check(bist_run == 0, "R4 enable cleared by update", {7'd0, bist_run}, 0);
    run_idle = 1'b0;

    // tlr clears both outputs and beats update
    do_capture();
    scan(RW + 1, 8'b00001, 8'b10101, "R5 bist recapture");
    do_update();
    settle();
    sel_bist = 1'b0; sel_user = 1'b1;
    scan(UW, 8'b111111, 8'b010011, "R1 user refill");
    step(); idle_strobes(); update_dr = 1'b1; tlr = 1'b1;
    settle();
    check(user_cfg == 0, "R7 tlr clears cfg over update", 8'(user_cfg), 0);
    sel_user = 1'b0; sel_bist = 1'b1; run_idle = 1'b1; #1;
    check(bist_run == 0, "R7 tlr clears enable", {7'd0, bist_run}, 0);
    run_idle = 1'b0;
    sel_bist = 1'b0;
    settle();
    check(exp_q.size() == 0, "R9 scoreboard drained", 8'(exp_q.size()), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule